// File: doc/BRIEF.md
# Block Erase Queue and Suspend Controller

This controller gathers a set of flash blocks to erase. Each block is named by a byte address on a select strobe. A selection window stays open until a fixed number of microsecond ticks have passed with no new selection, and every new selection restarts that count. When the window closes, the controller walks the chosen blocks one at a time, from the lowest block index up. Protected blocks are passed over without an error. For each remaining block it hands a request to a modelled array and waits for a done/fail handshake.

Byte addresses map onto an asymmetric top-boot layout with 19 blocks:
- Blocks 0 to 14 are fifteen 64 KB blocks covering 0x00000 to 0xEFFFF.
- Block 15 is a 32 KB block at 0xF0000 to 0xF7FFF.
- Blocks 16 and 17 are two 8 KB blocks at 0xF8000 to 0xF9FFF and 0xFA000 to 0xFBFFF.
- Block 18 is a 16 KB block at 0xFC000 to 0xFFFFF.

A suspend strobe has two behaviours:
- While the window is open, it freezes the operation at once.
- While a block is erasing, it takes effect after a latency.

A resume strobe restarts the erase. The status outputs report whether the window is open, whether the erase has begun, whether the controller is suspended, and whether a failure occurred. A program-permission output tells a neighbouring program path whether a given address may be written.

Top module: `erase_queue_ctrl`

## Requirements
- R1: A byte address maps to block index addr[19:16] when that nibble is below 0xF. Otherwise it maps to block 15 for 0xF0000..0xF7FFF, block 16 for 0xF8000..0xF9FFF, block 17 for 0xFA000..0xFBFFF and block 18 for 0xFC000..0xFFFFF.
- R2: The erase begins on the 50th microsecond tick that follows the most recent selection. Each selection made while the window is open restarts this count.
- R3: Selections made once the erase has begun, while suspended, or after a resume do not add blocks.
- R4: Selected unprotected blocks are requested one at a time in ascending index order. Selected protected blocks are never requested, and skipping them sets no error.
- R5: When every selected block is protected, no request is issued. The controller then goes idle on the 100th tick after the window closes.
- R6: A suspend while the window is open sets `suspended` at the next clock edge and stops the window. A resume then starts the erase at the next edge.
- R7: A suspend during erasing sets `suspended` on the 15th tick, or earlier if the current block finishes first. The interrupted block is requested again after resume. Suspend and resume may repeat.
- R8: `prog_ok` is 0 for an address in a protected block and 0 while the controller is active and not suspended. While suspended it is 0 for an address in a selected block, and it is 1 otherwise.
- R9: A done response with fail high sets that block's bit in `fail_map`. `err` rises when the erase completes if any bit is set. Both clear on the first selection of a new operation.
- R10: After reset the controller is idle: `busy`, `win_open`, `erase_started`, `suspended`, `erase_req` and `err` are 0, and `fail_map` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| sel_stb | input | 1 | Adds the block holding `sel_addr` |
| sel_addr | input | 20 | Byte address of the block to select |
| susp_stb | input | 1 | Suspend request |
| resume_stb | input | 1 | Resume request |
| prot_map | input | 19 | Protection bit per block |
| prog_addr | input | 20 | Byte address a program would target |
| erase_req | output | 1 | Requests erase of `erase_blk` from the array |
| erase_blk | output | 5 | Block index being erased |
| blk_done | input | 1 | Array pulse: current block finished |
| blk_fail | input | 1 | Qualifies `blk_done` as a failure |
| busy | output | 1 | Window open, erasing, or protected-only wait |
| win_open | output | 1 | Selection window is open |
| erase_started | output | 1 | Erase phase has begun and is not suspended |
| suspended | output | 1 | Operation is suspended |
| prog_ok | output | 1 | A program at `prog_addr` is allowed |
| err | output | 1 | Last erase had a failing block |
| fail_map | output | 19 | Failure bit per block |

## Verification
Timed results are measured in ticks rather than cycles. After the edge that registers a strobe, the bench counts the `us_tick` values present at each later rising edge and stops at the edge where the awaited output changes. That count must be 50 for the window, 15 for suspend latency and 100 for the protected-only wait.

Suspend-in-window and resume take effect at the first rising edge after the strobe, so those outputs are sampled at the falling edge after the strobe is removed. Erase order, the set of erased blocks and failure flags are logged from the array model's done pulses. They are compared once `busy` drops, against a set computed from the bench's own address map and the protection and fail masks.

// File: rtl/eq_pkg.sv
package eq_pkg;
    localparam int NBLK = 19;
    localparam int BW   = 5;
    localparam int AW   = 20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WIN, ST_WSUSP, ST_RUN, ST_SPEND, ST_SUSP, ST_PWAIT
    } eq_state_e;

    // top-boot asymmetric map: high nibble picks a 64 KB block, the top one is split
    function automatic logic [BW-1:0] blk_of(input logic [AW-1:0] a);
        if (a[19:16] != 4'hF)        return {1'b0, a[19:16]};
        else if (!a[15])             return BW'(15);
        else if (a[14:13] == 2'b00)  return BW'(16);
        else if (a[14:13] == 2'b01)  return BW'(17);
        else                         return BW'(18);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/eq_blkmap.sv
module eq_blkmap
    import eq_pkg::*;
(
    input  logic [AW-1:0] addr,
    output logic [BW-1:0] blk
);
    assign blk = blk_of(addr);
endmodule

// File: rtl/eq_timer.sv
module eq_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assign hit = tick && (cnt == limit - 1'b1);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < limit);
endmodule

// File: rtl/eq_pick.sv
module eq_pick #(
    parameter int N  = 19,
    parameter int BW = 5
) (
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [BW-1:0] idx
);
    logic [N:0]   lower;
    logic [N-1:0] grant;

    assign lower[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pri
        assign lower[i+1] = lower[i] | pend[i];
        assign grant[i]   = pend[i] & ~lower[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) idx = BW'(i);
    end

    assign any = lower[N];

    // R4
    onehot_grant_chk: assert final ($onehot0(grant));
endmodule

// File: rtl/erase_queue_ctrl.sv
module erase_queue_ctrl
    import eq_pkg::*;
#(
    parameter int WIN_US     = 50,
    parameter int ALLPROT_US = 100,
    parameter int SUSPLAT_US = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            us_tick,
    input  logic            sel_stb,
    input  logic [AW-1:0]   sel_addr,
    input  logic            susp_stb,
    input  logic            resume_stb,
    input  logic [NBLK-1:0] prot_map,
    input  logic [AW-1:0]   prog_addr,
    output logic            erase_req,
    output logic [BW-1:0]   erase_blk,
    input  logic            blk_done,
    input  logic            blk_fail,
    output logic            busy,
    output logic            win_open,
    output logic            erase_started,
    output logic            suspended,
    output logic            prog_ok,
    output logic            err,
    output logic [NBLK-1:0] fail_map
);
    localparam int TMAX = imax(imax(WIN_US, ALLPROT_US), SUSPLAT_US);
    localparam int CW   = $clog2(TMAX + 1);

    eq_state_e       state, state_n;
    logic [NBLK-1:0] sel_map, fin_map, fail_q;
    logic            err_q;
    logic [BW-1:0]   sel_blk, prog_blk, cur_blk;
    logic            any_pend, hit, tmr_clr, timing, win_restart;
    logic [CW-1:0]   limit;
    logic [NBLK-1:0] pend;

    eq_blkmap u_selmap (.addr(sel_addr),  .blk(sel_blk));
    eq_blkmap u_prgmap (.addr(prog_addr), .blk(prog_blk));

    assign pend = sel_map & ~prot_map & ~fin_map;

    eq_pick #(.N(NBLK), .BW(BW)) u_pick (.pend(pend), .any(any_pend), .idx(cur_blk));

    always_comb begin
        case (state)
            ST_SPEND: limit = CW'(SUSPLAT_US);
            ST_PWAIT: limit = CW'(ALLPROT_US);
            default:  limit = CW'(WIN_US);
        endcase
    end

    assign timing      = (state == ST_WIN) || (state == ST_SPEND) || (state == ST_PWAIT);
    assign win_restart = (state == ST_WIN) && sel_stb && !susp_stb;
    assign tmr_clr     = (state_n != state) || win_restart || !timing;

    eq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .tick(us_tick), .limit(limit), .hit(hit)
    );

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (sel_stb) state_n = ST_WIN;
            ST_WIN: begin
                if (susp_stb)            state_n = ST_WSUSP;
                else if (sel_stb)        state_n = ST_WIN;
                else if (hit)            state_n = any_pend ? ST_RUN : ST_PWAIT;
            end
            ST_WSUSP: if (resume_stb) state_n = any_pend ? ST_RUN : ST_PWAIT;
            ST_RUN: begin
                if (!any_pend)           state_n = ST_IDLE;
                else if (susp_stb)       state_n = ST_SPEND;
            end
            ST_SPEND: if (blk_done || hit) state_n = ST_SUSP;
            ST_SUSP:  if (resume_stb) state_n = ST_RUN;
            ST_PWAIT: if (hit)        state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    assign erase_req = ((state == ST_RUN) || (state == ST_SPEND)) && any_pend;
    assign erase_blk = cur_blk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sel_map <= '0;
            fin_map <= '0;
            fail_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && sel_stb) begin
                sel_map <= NBLK'(1) << sel_blk;
                fin_map <= '0;
                fail_q  <= '0;
                err_q   <= 1'b0;
            end else if (win_restart) begin
                sel_map[sel_blk] <= 1'b1;
            end
            if (erase_req && blk_done) begin
                fin_map[cur_blk] <= 1'b1;
                fail_q[cur_blk]  <= blk_fail;
            end
            if (state == ST_RUN && !any_pend)
                err_q <= |fail_q;
        end
    end

    assign busy          = timing || (state == ST_RUN);
    assign win_open      = (state == ST_WIN);
    assign erase_started = (state == ST_RUN) || (state == ST_SPEND) || (state == ST_PWAIT);
    assign suspended     = (state == ST_WSUSP) || (state == ST_SUSP);
    assign err           = err_q;
    assign fail_map      = fail_q;
    assign prog_ok       = !prot_map[prog_blk] && !busy && !(suspended && sel_map[prog_blk]);

    // R3
    sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_started || suspended) |=> $stable(sel_map));
    // R6
    win_susp_chk: assert property (@(posedge clk) disable iff (rst)
        (win_open && susp_stb) |=> suspended);
    // R4
    req_unprot_chk: assert property (@(posedge clk) disable iff (rst)
        erase_req |-> (!prot_map[erase_blk] && sel_map[erase_blk]));
    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (fail_map != '0));
endmodule

// File: tb/sim_erase_queue_ctrl.sv
module sim_erase_queue_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        sel_stb = 1'b0, susp_stb = 1'b0, resume_stb = 1'b0;
    logic [19:0] sel_addr = '0, prog_addr = '0;
    logic [18:0] prot_map = '0;
    logic        blk_done = 1'b0, blk_fail = 1'b0;
    logic        erase_req, busy, win_open, erase_started, suspended, prog_ok, err;
    logic [4:0]  erase_blk;
    logic [18:0] fail_map;

    int checks = 0, failures = 0;
    int arr_len = 20;
    int acnt = 0;
    int tdiv = 0;
    int last_blk = -1;
    logic [18:0] fail_mask = '0;
    logic [18:0] done_log = '0;
    logic        order_bad = 1'b0;

    always #10 clk = ~clk;

    erase_queue_ctrl u0 (
        .clk(clk), .rst(rst), .us_tick(us_tick), .sel_stb(sel_stb), .sel_addr(sel_addr),
        .susp_stb(susp_stb), .resume_stb(resume_stb), .prot_map(prot_map),
        .prog_addr(prog_addr), .erase_req(erase_req), .erase_blk(erase_blk),
        .blk_done(blk_done), .blk_fail(blk_fail), .busy(busy), .win_open(win_open),
        .erase_started(erase_started), .suspended(suspended), .prog_ok(prog_ok),
        .err(err), .fail_map(fail_map)
    );

    always @(negedge clk) begin
        tdiv    = (tdiv == 4) ? 0 : tdiv + 1;
        us_tick = (tdiv == 4);
    end

    // array model: done after arr_len requested cycles, logs completion order
    always @(negedge clk) begin
        if (rst) begin
            acnt = 0; blk_done = 1'b0; blk_fail = 1'b0;
        end else if (blk_done) begin
            blk_done = 1'b0; blk_fail = 1'b0;
        end else if (erase_req) begin
            if (acnt >= arr_len - 1) begin
                blk_done = 1'b1;
                blk_fail = fail_mask[erase_blk];
                if (int'(erase_blk) <= last_blk) order_bad = 1'b1;
                last_blk = int'(erase_blk);
                done_log[erase_blk] = 1'b1;
                acnt = 0;
            end else acnt++;
        end else acnt = 0;
    end

    function automatic int exp_blk(input logic [19:0] a);
        if (a < 20'hF0000)      return int'(a / 20'h10000);
        else if (a < 20'hF8000) return 15;
        else if (a < 20'hFA000) return 16;
        else if (a < 20'hFC000) return 17;
        else                    return 18;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_sel(input logic [19:0] a);
        @(negedge clk); sel_stb = 1'b1; sel_addr = a;
        @(negedge clk); sel_stb = 1'b0;
    endtask
    task automatic pulse_susp();
        @(negedge clk); susp_stb = 1'b1;
        @(negedge clk); susp_stb = 1'b0;
    endtask
    task automatic pulse_res();
        @(negedge clk); resume_stb = 1'b1;
        @(negedge clk); resume_stb = 1'b0;
    endtask

    // mode 0: window closed, 1: suspended, 2: not busy, 3: just count to lim ticks
    task automatic ticks_until(input int mode, input int lim, output int n);
        n = 0;
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk); #1;
            if (us_tick) n++;
            if (mode == 0 && !win_open) break;
            if (mode == 1 && suspended) break;
            if (mode == 2 && !busy) break;
            if (mode == 3 && n == lim) break;
        end
    endtask

    task automatic new_op(input logic [18:0] fm);
        fail_mask = fm; done_log = '0; order_bad = 1'b0; last_blk = -1;
    endtask

    initial begin
        int n;
        logic [18:0] exp_sel, exp_done, oh;
        logic [19:0] a;
        logic [19:0] bnd [10];
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 idle", {busy, win_open, erase_started, suspended, erase_req, err},  6'b0);
        chk("R10 fail_map", 32'(fail_map), 32'd0);

        // R1 boundaries through the protection path of prog_ok (R8)
        bnd = '{20'h00000, 20'hEFFFF, 20'hF0000, 20'hF7FFF, 20'hF8000,
                20'hF9FFF, 20'hFA000, 20'hFBFFF, 20'hFC000, 20'hFFFFF};
        foreach (bnd[i]) begin
            oh = 19'd1 << exp_blk(bnd[i]);
            prog_addr = bnd[i]; prot_map = oh;
            #1 chk("R1 map protected", 32'(prog_ok), 32'd0);
            prot_map = ~oh;
            #1 chk("R1 map free", 32'(prog_ok), 32'd1);
        end
        for (int k = 0; k < 8; k++) begin
            a = 20'($urandom);
            prog_addr = a; prot_map = 19'd1 << exp_blk(a);
            #1 chk("R1 map random", 32'(prog_ok), 32'd0);
        end
        prot_map = '0;

        // R2 window length and restart
        new_op('0);
        pulse_sel(20'h20000);
        ticks_until(0, 0, n);
        chk("R2 window ticks", 32'(n), 32'd50);
        ticks_until(2, 0, n);
        chk("R4 single block", 32'(done_log), 32'h4);
        new_op('0);
        pulse_sel(20'h30000);
        ticks_until(3, 30, n);
        pulse_sel(20'h50000);
        ticks_until(0, 0, n);
        chk("R2 restarted window ticks", 32'(n), 32'd50);
        // R3 selection after start ignored
        pulse_sel(20'h90000);
        ticks_until(2, 0, n);
        chk("R3 late select ignored", 32'(done_log), 32'h28);
        chk("R4 ascending order", 32'(order_bad), 32'd0);

        // R5 all selected blocks protected
        new_op('0);
        prot_map = 19'h40;
        pulse_sel(20'h60000);
        ticks_until(0, 0, n);
        chk("R5 started flag", 32'(erase_started), 32'd1);
        ticks_until(2, 0, n);
        chk("R5 protected wait ticks", 32'(n), 32'd100);
        chk("R5 no request", 32'(done_log), 32'd0);
        chk("R4 no error on skip", 32'(err), 32'd0);

        // R6 suspend in window, resume starts at once
        new_op('0);
        prot_map = '0;
        pulse_sel(20'h40000);
        pulse_susp();
        chk("R6 suspended at once", 32'(suspended), 32'd1);
        chk("R6 window stopped", 32'(win_open), 32'd0);
        ticks_until(3, 60, n);
        chk("R6 still suspended", 32'({suspended, erase_started}), 32'b10);
        pulse_sel(20'h70000);
        pulse_res();
        chk("R6 resume starts", 32'({erase_req, erase_started}), 32'b11);
        pulse_sel(20'h80000);
        ticks_until(2, 0, n);
        chk("R3 no add after resume", 32'(done_log), 32'h10);

        // R7 suspend while erasing, repeated, and R8 during suspend
        new_op('0);
        arr_len = 400;
        prot_map = 19'h200;
        pulse_sel(20'h3_1234);
        pulse_sel(20'h7_0000);
        ticks_until(0, 0, n);
        pulse_susp();
        ticks_until(1, 0, n);
        chk("R7 suspend latency", 32'(n), 32'd15);
        chk("R7 request dropped", 32'(erase_req), 32'd0);
        prog_addr = 20'h3_FFFF;
        #1 chk("R8 selected block blocked", 32'(prog_ok), 32'd0);
        prog_addr = 20'h9_0000;
        #1 chk("R8 protected block blocked", 32'(prog_ok), 32'd0);
        prog_addr = 20'hB_0000;
        #1 chk("R8 other block allowed", 32'(prog_ok), 32'd1);
        pulse_res();
        chk("R7 interrupted block again", 32'({erase_req, erase_blk}), 32'h23);
        prog_addr = 20'hB_0000;
        #1 chk("R8 blocked while active", 32'(prog_ok), 32'd0);
        pulse_susp();
        ticks_until(1, 0, n);
        chk("R7 second suspend latency", 32'(n), 32'd15);
        pulse_res();
        ticks_until(2, 0, n);
        chk("R7 both erased", 32'(done_log), 32'h88);
        arr_len = 20;

        // R9 failure flag and clearing
        new_op(19'h4);
        prot_map = '0;
        pulse_sel(20'h1_0000);
        pulse_sel(20'h2_0000);
        ticks_until(2, 0, n);
        chk("R9 err set", 32'(err), 32'd1);
        chk("R9 fail_map", 32'(fail_map), 32'h4);
        new_op('0);
        pulse_sel(20'h5_0000);
        chk("R9 cleared on new op", 32'({err, fail_map}), 32'd0);
        ticks_until(2, 0, n);

        // random operations: R1 R3 R4 R9
        for (int it = 0; it < 8; it++) begin
            int cnt;
            prot_map = 19'($urandom) & 19'($urandom);
            new_op(19'($urandom) & 19'($urandom) & 19'($urandom));
            cnt = 1 + int'($urandom % 3);
            exp_sel = '0;
            for (int s = 0; s < cnt; s++) begin
                a = 20'($urandom);
                exp_sel |= 19'd1 << exp_blk(a);
                pulse_sel(a);
                repeat (int'($urandom % 7)) @(negedge clk);
            end
            ticks_until(2, 0, n);
            exp_done = exp_sel & ~prot_map;
            chk("R4 random erased set", 32'(done_log), 32'(exp_done));
            chk("R4 random order", 32'(order_bad), 32'd0);
            chk("R9 random fail_map", 32'(fail_map), 32'(exp_done & fail_mask));
            chk("R9 random err", 32'(err), 32'(|(exp_done & fail_mask)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule